// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block is the receive front end of an asynchronous serial port. It takes the raw RX line and a tick that pulses sixteen times per bit period. It finds each start bit and samples every bit at its middle. It shifts the data in least significant bit first and checks the optional parity bit and the stop bit. When the line is held low for a whole character, it reports a break instead of a character.

Each received character appears on the outputs for one cycle, marked by a strobe, together with three error tags: parity, framing and break. The data and tags stay on the outputs until the next character. The character length and parity are set by static configuration inputs.

The receiver has two recovery behaviours. A low stop bit is taken as the start bit of the next character, so the receiver stays locked onto back-to-back traffic. After a break, the receiver waits for the line to go high before it looks for another start bit.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset, char_valid_o, char_data_o, perr_o, ferr_o and brk_o are all zero.
- R2: Data bits are taken least significant bit first, each sampled mid-bit. The data length is 5, 6, 7 or 8 bits for dbits_sel_i = 0, 1, 2 or 3. The received value appears right-aligned on char_data_o, with the unused upper bits zero.
- R3: With par_en_i = 1, one parity bit follows the data. par_odd_i = 0 selects even parity (data plus parity bit hold an even number of ones) and par_odd_i = 1 selects odd parity. A correct parity bit gives perr_o = 0.
- R4: A parity bit of the wrong value sets perr_o with the character, and the data is still delivered intact.
- R5: A stop bit sampled as 0 sets ferr_o with the character.
- R6: After a low stop bit that is not a break, that low level counts as the start bit of the next character, so data bits that follow with no idle gap are received correctly.
- R7: A low pulse on the line that has ended by the middle of the start bit (8 ticks after detection) is discarded, and no character is produced.
- R8: A line held low through the start bit, all data bits, the parity bit if enabled, and the stop bit yields one character with brk_o = 1, ferr_o = 1, perr_o = 0 and zero data.
- R9: After a break, no further character is produced while the line stays low. Reception resumes normally once the line has returned high.
- R10: char_valid_o is a single-cycle pulse, one per character, raised in the cycle after the stop-bit sample point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous serial line, high when idle |
| os_tick_i | input | 1 | Oversampling enable, 16 pulses per bit period |
| dbits_sel_i | input | 2 | Data length: 0 to 3 selects 5 to 8 bits |
| par_en_i | input | 1 | 1 = a parity bit follows the data |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| char_valid_o | output | 1 | One-cycle strobe for a received character |
| char_data_o | output | 8 | Received data, right-aligned |
| perr_o | output | 1 | Parity error tag of the character |
| ferr_o | output | 1 | Framing error tag of the character |
| brk_o | output | 1 | Break tag of the character |

## Verification
The hardest case to reach is resynchronisation after a framing error. The line must go from a low stop bit straight into the next character's data bits with no high gap, so the only thing that marks the new character is the stop bit itself. The bench drives the line bit-accurately at 64 clocks per bit and emits the second character with its own start bit left out. The break case comes next: the bench holds the line low for four character times, checks that exactly one tagged character was produced, and then confirms that a normal frame after the return to high is still received.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  parameter int unsigned DW_MAX = 8;
  localparam int unsigned NW = $clog2(DW_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } rx_state_e;

  typedef struct packed {
    logic [DW_MAX-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_char_t;

  // data length encoded by the 2-bit select: DW_MAX-3 .. DW_MAX
  function automatic logic [NW-1:0] width_of(input logic [1:0] sel);
    return NW'(DW_MAX - 3) + NW'(sel);
  endfunction

  // 1 when data plus parity bit do not match the selected sense
  function automatic logic parity_bad(input logic [DW_MAX-1:0] d,
                                      input logic pbit, input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction

  // bits enter at the top of the shift register; move them down
  function automatic logic [DW_MAX-1:0] align(input logic [DW_MAX-1:0] sh,
                                              input logic [NW-1:0] n);
    return sh >> (NW'(DW_MAX) - n);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/rx_char_fsm.sv
module rx_char_fsm
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] dbits_sel_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  output logic       stop_ev_o,
  output logic       reject_ev_o,
  output logic       brk_wait_o,
  output rx_char_t   char_o
);
  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned HALF = OVS / 2;
  localparam logic [CW-1:0] LIM_HALF = CW'(HALF - 1);
  localparam logic [CW-1:0] LIM_FULL = CW'(OVS - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [NW-1:0]     bit_idx;
  logic [DW_MAX-1:0] shreg;
  logic              pbit;
  logic              zacc;

  logic [NW-1:0]     nbits;
  logic [CW-1:0]     limit;
  logic              sample;
  logic              brk_now;
  logic [DW_MAX-1:0] data_al;

  always_comb begin
    nbits   = width_of(dbits_sel_i);
    limit   = (state == ST_START) ? LIM_HALF : LIM_FULL;
    sample  = tick_i && (cnt == limit);
    brk_now = zacc && !rx_i;
    data_al = align(shreg, nbits);
  end

  assign stop_ev_o   = (state == ST_STOP) && sample;
  assign reject_ev_o = (state == ST_START) && sample && rx_i;
  assign brk_wait_o  = (state == ST_BRK);

  always_comb begin
    char_o.data = data_al;
    char_o.brk  = brk_now;
    char_o.ferr = !rx_i;
    char_o.perr = par_en_i && !brk_now && parity_bad(data_al, pbit, par_odd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      zacc    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (tick_i && !rx_i) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_BRK: begin
          if (tick_i && rx_i) state <= ST_IDLE;
        end
        default: begin
          if (tick_i) begin
            if (!sample) begin
              cnt <= cnt + 1'b1;
            end else begin
              cnt <= '0;
              unique case (state)
                ST_START: begin
                  if (rx_i) begin
                    state <= ST_IDLE;
                  end else begin
                    state   <= ST_DATA;
                    bit_idx <= '0;
                    zacc    <= 1'b1;
                  end
                end
                ST_DATA: begin
                  shreg <= {rx_i, shreg[DW_MAX-1:1]};
                  zacc  <= zacc && !rx_i;
                  if (bit_idx == NW'(nbits - 1'b1)) begin
                    state <= par_en_i ? ST_PAR : ST_STOP;
                  end else begin
                    bit_idx <= bit_idx + 1'b1;
                  end
                end
                ST_PAR: begin
                  pbit  <= rx_i;
                  zacc  <= zacc && !rx_i;
                  state <= ST_STOP;
                end
                default: begin
                  if (brk_now) begin
                    state <= ST_BRK;
                  end else if (!rx_i) begin
                    state   <= ST_DATA;
                    bit_idx <= '0;
                    zacc    <= 1'b1;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
              endcase
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_result_reg.sv
module rx_result_reg
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  rx_char_t char_i,
  output logic     valid_o,
  output rx_char_t char_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      char_o  <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) char_o <= char_i;
    end
  end
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS_RATE    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              os_tick_i,
  input  logic [1:0]        dbits_sel_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              char_valid_o,
  output logic [DW_MAX-1:0] char_data_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o
);
  logic     rx_s;
  logic     ev_stop;
  logic     ev_reject;
  logic     brk_wait;
  rx_char_t char_w;
  rx_char_t char_q;

  rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (rx_i),
    .sync_o  (rx_s)
  );

  rx_char_fsm #(.OVS(OVS_RATE)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (os_tick_i),
    .rx_i        (rx_s),
    .dbits_sel_i (dbits_sel_i),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .stop_ev_o   (ev_stop),
    .reject_ev_o (ev_reject),
    .brk_wait_o  (brk_wait),
    .char_o      (char_w)
  );

  rx_result_reg out_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (ev_stop),
    .char_i  (char_w),
    .valid_o (char_valid_o),
    .char_o  (char_q)
  );

  assign char_data_o = char_q.data;
  assign perr_o      = char_q.perr;
  assign ferr_o      = char_q.ferr;
  assign brk_o       = char_q.brk;
endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_s,
  input logic       ev_stop,
  input logic       ev_reject,
  input logic       brk_wait,
  input logic       char_valid_o,
  input logic [7:0] char_data_o,
  input logic       perr_o,
  input logic       ferr_o,
  input logic       brk_o
);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid_o |=> !char_valid_o);

  a_r10_valid_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> char_valid_o);

  a_r10_valid_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid_o |-> $past(ev_stop));

  a_r8_break_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid_o && brk_o) |-> (ferr_o && !perr_o && char_data_o == 8'h00));

  a_r9_quiet_in_break: assert property (@(posedge clk) disable iff (!rst_n)
    brk_wait |-> !ev_stop);

  a_r9_hold_until_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_wait && !rx_s) |=> brk_wait);

  a_r7_glitch_no_char: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> !char_valid_o);

  a_r5_low_stop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !rx_s) |=> (char_valid_o && ferr_o));
endmodule

bind uart_rx_brk uart_rx_brk_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_s         (rx_s),
  .ev_stop      (ev_stop),
  .ev_reject    (ev_reject),
  .brk_wait     (brk_wait),
  .char_valid_o (char_valid_o),
  .char_data_o  (char_data_o),
  .perr_o       (perr_o),
  .ferr_o       (ferr_o),
  .brk_o        (brk_o)
);

// File: tb/uart_rx_brk_tb_top.sv
`timescale 1ns/1ps
module uart_rx_brk_tb_top;
  localparam int TDIV     = 4;
  localparam int BIT_CLKS = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_i = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] dbits_sel = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       char_valid;
  logic [7:0] char_data;
  logic       perr, ferr, brk;

  int checks = 0;
  int failures = 0;
  int tdiv_cnt = 0;

  int         cap_n = 0;
  logic [7:0] cap_d [0:15];
  logic       cap_p [0:15];
  logic       cap_f [0:15];
  logic       cap_b [0:15];
  logic       prev_valid = 1'b0;
  int         wide_pulses = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    tick     <= (tdiv_cnt == TDIV - 1);
  end

  uart_rx_brk dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_i         (rx_i),
    .os_tick_i    (tick),
    .dbits_sel_i  (dbits_sel),
    .par_en_i     (par_en),
    .par_odd_i    (par_odd),
    .char_valid_o (char_valid),
    .char_data_o  (char_data),
    .perr_o       (perr),
    .ferr_o       (ferr),
    .brk_o        (brk)
  );

  always @(negedge clk) begin
    if (rst_n && char_valid) begin
      if (cap_n < 16) begin
        cap_d[cap_n] = char_data;
        cap_p[cap_n] = perr;
        cap_f[cap_n] = ferr;
        cap_b[cap_n] = brk;
      end
      cap_n = cap_n + 1;
    end
    if (prev_valid && char_valid) wide_pulses = wide_pulses + 1;
    prev_valid = char_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_i = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
  endtask

  task automatic send_frame(input logic [7:0] d, input int n, input bit pflip,
                            input logic stopv, input bit with_start);
    logic [7:0] m;
    logic       p;
    m = d & 8'((1 << n) - 1);
    p = (^m) ^ par_odd ^ pflip;
    if (with_start) drive_bit(1'b0);
    for (int i = 0; i < n; i++) drive_bit(m[i]);
    if (par_en) drive_bit(p);
    drive_bit(stopv);
  endtask

  task automatic expect_char(input int idx, input logic [7:0] d, input logic p,
                             input logic f, input logic b, input string req);
    check(cap_d[idx] == d, {req, " data"}, cap_d[idx], d);
    check(cap_p[idx] == p, {req, " perr"}, cap_p[idx], p);
    check(cap_f[idx] == f, {req, " ferr"}, cap_f[idx], f);
    check(cap_b[idx] == b, {req, " brk"}, cap_b[idx], b);
  endtask

  // R1: outputs after reset
  task automatic t_reset();
    @(negedge clk);
    check(char_valid == 1'b0, "R1 valid", char_valid, 0);
    check(char_data == 8'h00, "R1 data", char_data, 0);
    check({perr, ferr, brk} == 3'b000, "R1 flags", {perr, ferr, brk}, 0);
  endtask

  // R2: each data length, LSB first, no parity
  task automatic t_lengths();
    logic [7:0] vals [0:3];
    vals[0] = 8'h13; vals[1] = 8'h2D; vals[2] = 8'h5A; vals[3] = 8'hA5;
    par_en = 1'b0;
    for (int s = 0; s < 4; s++) begin
      dbits_sel = 2'(s);
      cap_n = 0;
      idle_bits(2);
      send_frame(vals[s], 5 + s, 1'b0, 1'b1, 1'b1);
      idle_bits(1);
      check(cap_n == 1, "R2 count", cap_n, 1);
      expect_char(0, vals[s], 1'b0, 1'b0, 1'b0, "R2");
    end
  endtask

  // R3 / R4: parity good and bad, even and odd
  task automatic t_parity();
    dbits_sel = 2'd3;
    par_en = 1'b1;
    for (int o = 0; o < 2; o++) begin
      par_odd = 1'(o);
      cap_n = 0;
      idle_bits(2);
      send_frame(8'hB7, 8, 1'b0, 1'b1, 1'b1);
      idle_bits(2);
      send_frame(8'h6C, 8, 1'b1, 1'b1, 1'b1);
      idle_bits(1);
      check(cap_n == 2, "R3 count", cap_n, 2);
      expect_char(0, 8'hB7, 1'b0, 1'b0, 1'b0, "R3");
      expect_char(1, 8'h6C, 1'b1, 1'b0, 1'b0, "R4");
    end
    par_en = 1'b0;
    par_odd = 1'b0;
  endtask

  // R5 / R6: low stop bit, then next character with no start bit of its own
  task automatic t_framing();
    dbits_sel = 2'd3;
    cap_n = 0;
    idle_bits(2);
    send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1);
    send_frame(8'hC3, 8, 1'b0, 1'b1, 1'b0);
    idle_bits(2);
    check(cap_n == 2, "R6 count", cap_n, 2);
    expect_char(0, 8'h3C, 1'b0, 1'b1, 1'b0, "R5");
    expect_char(1, 8'hC3, 1'b0, 1'b0, 1'b0, "R6");
  endtask

  // R7: short low pulse rejected, then a normal frame
  task automatic t_glitch();
    cap_n = 0;
    idle_bits(2);
    rx_i = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rx_i = 1'b1;
    idle_bits(3);
    check(cap_n == 0, "R7 glitch", cap_n, 0);
    send_frame(8'h81, 8, 1'b0, 1'b1, 1'b1);
    idle_bits(1);
    check(cap_n == 1, "R7 recover", cap_n, 1);
    expect_char(0, 8'h81, 1'b0, 1'b0, 1'b0, "R7");
  endtask

  // R8 / R9: long low line, then marking and a normal frame
  task automatic t_break();
    dbits_sel = 2'd3;
    cap_n = 0;
    idle_bits(2);
    for (int i = 0; i < 40; i++) drive_bit(1'b0);
    check(cap_n == 1, "R9 single char while low", cap_n, 1);
    expect_char(0, 8'h00, 1'b0, 1'b1, 1'b1, "R8");
    idle_bits(2);
    send_frame(8'h5A, 8, 1'b0, 1'b1, 1'b1);
    idle_bits(1);
    check(cap_n == 2, "R9 resume", cap_n, 2);
    expect_char(1, 8'h5A, 1'b0, 1'b0, 1'b0, "R9");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle_bits(1);
    t_lengths();
    t_parity();
    t_framing();
    t_glitch();
    t_break();
    // R10: every strobe lasted exactly one cycle
    check(wide_pulses == 0, "R10 pulse width", wide_pulses, 0);
    finish_run();
  end
endmodule